// File: doc/BRIEF.md
# DMA Channel Command and Status Register Slice

This block holds the software-visible registers of one DMA channel. It sits on a simple 32-bit register bus. The bus gives a byte address inside the channel's 64-byte window, a write strobe, write data and combinational read data. The block also connects to the transfer engine that moves the data. It keeps a configuration word and a next-link address, and the engine uses both. It drives an enable level to the engine, together with single-cycle pulses for software reset, software trigger, request clear and interrupt-mask clear.

The command register is write-one-to-act. Each bit set in a write to it performs one action, and bits left at zero change nothing. It has separate bits to set and to clear the enable, and one clear bit for each flag. Back from the engine come end, terminal-count, error and suspend events. The block holds each event as a sticky flag, shows the flags in a read-only status word, and raises a level interrupt while the end flag or the error flag is set.

A driver starts the channel in this order, while the channel is idle:
- write the next-link address;
- write the configuration;
- write a lone software reset;
- write the enable, adding the trigger bit for memory-to-memory work.

To stop the channel, it writes every clear bit together with the software reset in one command write.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every register, flag, pulse and the interrupt are zero, and a read of any offset returns zero.
- R2: A write to offset 0x2C loads the configuration word and a write to offset 0x38 loads the next-link address. Both read back unchanged and drive `cfg_q` / `next_link_q` from the next cycle. No command, not even a software reset, changes them.
- R3: A read of the command register (offset 0x28) returns zero. A read of any offset other than 0x24, 0x2C and 0x38 also returns zero.
- R4: Command bit 0 sets the enable and bit 1 clears it, in the cycle after the write. A write that holds both bits clears the enable. The enable shows as status bit 0 and on `run_en`.
- R5: Command bits 2 (trigger), 3 (software reset), 4 (request clear) and 17 (interrupt-mask clear) each produce a pulse on their own output. The pulse is high for exactly the one cycle after the write.
- R6: An end event sets the end flag (status bit 5) and raises `irq`. Command bit 5 clears the end flag and leaves the enable unchanged. If the end event arrives in the same cycle as the clear, the flag stays set.
- R7: A terminal-count event sets status bit 6, and command bit 6 clears it. A suspend event sets status bit 7, and command bit 9 clears it. If the event and the clear arrive in the same cycle, the event wins.
- R8: An error event sets the error flag (status bit 4), raises `irq` and clears the enable at the same edge. This holds even when a set-enable write arrives in the same cycle. Only a software reset clears the error flag.
- R9: A software reset (command bit 3) clears the enable and all four flags in one cycle. It overrides any event that arrives in the same cycle.
- R10: The stop word 0x0002027A is every clear bit plus software reset, without set-enable or trigger. Writing it leaves status at zero and `irq` low, whatever the channel's state was before.
- R11: The start-up order is next-link write, configuration write, lone reset, then set-enable with trigger (0x5). The enable stays low through the first three writes and rises only after the last one, in the same cycle as the trigger pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset within the channel window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_end | input | 1 | End event from the engine |
| ev_tc | input | 1 | Terminal-count event from the engine |
| ev_err | input | 1 | Error event from the engine |
| ev_susp | input | 1 | Suspend event from the engine |
| run_en | output | 1 | Channel enable level to the engine |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |
| trig_pulse | output | 1 | One-cycle software trigger pulse |
| clr_req_pulse | output | 1 | One-cycle request-clear pulse |
| clr_mask_pulse | output | 1 | One-cycle interrupt-mask-clear pulse |
| cfg_q | output | 32 | Stored configuration word |
| next_link_q | output | 32 | Stored next-link address |
| irq | output | 1 | Level interrupt: end flag OR error flag |

## Verification
The bench aims at collisions in which an event and a command land in the same cycle.

| Collision | Required outcome | What a wrong design would do |
|---|---|---|
| End event and clear-end together | The flag stays set | Lose the completion |
| Error event and set-enable together | The enable ends low | Leave a faulted channel running |
| Software reset during an end event | All flags end clear | Leave a stale interrupt |
| Set-enable and clear-enable together | The enable ends low (clear wins) | Enable the channel |

It also checks three more cases:
- The clear-end write leaves the enable unchanged. A design with a read-modify-write shortcut would drop the enable.
- The software reset leaves the configuration and link registers alone. A design that reset them would lose the start-up setup.
- The lone reset in the start-up order does not start the channel. A design that started there would run before the enable write.

// File: rtl/dma_chan_csr.sv
module dma_chan_csr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_end,
  input  logic              ev_tc,
  input  logic              ev_err,
  input  logic              ev_susp,
  output logic              run_en,
  output logic              soft_rst_pulse,
  output logic              trig_pulse,
  output logic              clr_req_pulse,
  output logic              clr_mask_pulse,
  output logic [31:0]       cfg_q,
  output logic [31:0]       next_link_q,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'('h2C);
  localparam logic [ADDR_W-1:0] OFS_LINK = ADDR_W'('h38);

  logic en_q, end_q, tc_q, err_q, sus_q;

  wire cmd_wr  = bus_we && (bus_addr == OFS_CMD);
  wire c_set   = cmd_wr && bus_wdata[0];
  wire c_clr   = cmd_wr && bus_wdata[1];
  wire c_rst   = cmd_wr && bus_wdata[3];
  wire c_clrend = cmd_wr && bus_wdata[5];
  wire c_clrtc  = cmd_wr && bus_wdata[6];
  wire c_clrsus = cmd_wr && bus_wdata[9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; end_q <= 1'b0; tc_q <= 1'b0; err_q <= 1'b0; sus_q <= 1'b0;
      soft_rst_pulse <= 1'b0; trig_pulse <= 1'b0;
      clr_req_pulse <= 1'b0; clr_mask_pulse <= 1'b0;
      cfg_q <= '0; next_link_q <= '0;
    end else begin
      soft_rst_pulse <= c_rst;
      trig_pulse     <= cmd_wr && bus_wdata[2];
      clr_req_pulse  <= cmd_wr && bus_wdata[4];
      clr_mask_pulse <= cmd_wr && bus_wdata[17];
      if (bus_we && bus_addr == OFS_CFG)  cfg_q <= bus_wdata;
      if (bus_we && bus_addr == OFS_LINK) next_link_q <= bus_wdata;
      if (c_rst) begin
        en_q <= 1'b0; end_q <= 1'b0; tc_q <= 1'b0; err_q <= 1'b0; sus_q <= 1'b0;
      end else begin
        en_q  <= !(ev_err || c_clr) && (en_q || c_set);
        end_q <= ev_end  || (end_q && !c_clrend);
        tc_q  <= ev_tc   || (tc_q  && !c_clrtc);
        sus_q <= ev_susp || (sus_q && !c_clrsus);
        err_q <= ev_err  || err_q;
      end
    end
  end

  assign run_en = en_q;
  assign irq    = end_q || err_q;

  always_comb begin
    case (bus_addr)
      OFS_STAT: bus_rdata = {24'd0, sus_q, tc_q, end_q, err_q, 3'd0, en_q};
      OFS_CFG:  bus_rdata = cfg_q;
      OFS_LINK: bus_rdata = next_link_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              ev_err,
  input logic              run_en,
  input logic              trig_pulse,
  input logic              irq,
  input logic [31:0]       cfg_q
);
  wire is_cmd = bus_we && (bus_addr == ADDR_W'('h28));
  wire is_cfg = bus_we && (bus_addr == ADDR_W'('h2C));

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_cfg |=> cfg_q == $past(bus_wdata));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cfg |=> $stable(cfg_q));

  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && bus_wdata[0] && bus_wdata[1]) |=> !run_en);

  p_trig_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && bus_wdata[2]) |=> trig_pulse);

  p_trig_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_cmd && bus_wdata[2]) |=> !trig_pulse);

  p_clrend_keeps_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && bus_wdata[5] && !bus_wdata[0] && !bus_wdata[1] && !bus_wdata[3] && !ev_err)
      |=> run_en == $past(run_en));

  p_err_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !(is_cmd && bus_wdata[3])) |=> (!run_en && irq));

  p_reset_quiets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && bus_wdata[3]) |=> (!run_en && !irq));
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dma_chan_csr.sv
`timescale 1ns/1ps
module sim_dma_chan_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ev_end = 0, ev_tc = 0, ev_err = 0, ev_susp = 0;
  logic run_en, soft_rst_pulse, trig_pulse, clr_req_pulse, clr_mask_pulse, irq;
  logic [31:0] cfg_q, next_link_q;

  always #4 clk = ~clk;

  dma_chan_csr #(.ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_end(ev_end), .ev_tc(ev_tc), .ev_err(ev_err), .ev_susp(ev_susp),
    .run_en(run_en), .soft_rst_pulse(soft_rst_pulse), .trig_pulse(trig_pulse),
    .clr_req_pulse(clr_req_pulse), .clr_mask_pulse(clr_mask_pulse),
    .cfg_q(cfg_q), .next_link_q(next_link_q), .irq(irq));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_en, m_end, m_tc, m_err, m_sus;
  bit m_prst, m_ptrig, m_preq, m_pmask;
  int unsigned m_cfg, m_link;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a == 6'h24) return (m_sus << 7) | (m_tc << 6) | (m_end << 5) | (m_err << 4) | m_en;
    if (a == 6'h2C) return m_cfg;
    if (a == 6'h38) return m_link;
    return 0;
  endfunction

  task automatic compare(input string req, input logic [5:0] a);
    chk(req, "rdata",  bus_rdata, model_read(a));
    chk(req, "run_en", run_en, m_en);
    chk(req, "irq",    irq, m_end | m_err);
    chk(req, "pulses", {soft_rst_pulse, trig_pulse, clr_req_pulse, clr_mask_pulse},
        {m_prst, m_ptrig, m_preq, m_pmask});
    chk(req, "cfg_q",  cfg_q, m_cfg);
    chk(req, "link_q", next_link_q, m_link);
  endtask

  // ev: [0]=end [1]=tc [2]=err [3]=susp
  task automatic step(input logic [5:0] a, input logic we, input logic [31:0] d,
                      input logic [3:0] ev, input string req);
    int unsigned cmd;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
    {ev_susp, ev_err, ev_tc, ev_end} = ev;
    cmd = (we && a == 6'h28) ? d : 0;
    @(posedge clk);
    #1;
    m_prst = cmd[3]; m_ptrig = cmd[2]; m_preq = cmd[4]; m_pmask = cmd[17];
    if (we && a == 6'h2C) m_cfg = d;
    if (we && a == 6'h38) m_link = d;
    if (cmd[3]) begin
      m_en = 0; m_end = 0; m_tc = 0; m_err = 0; m_sus = 0;
    end else begin
      if (ev[2] || cmd[1]) m_en = 0;
      else if (cmd[0]) m_en = 1;
      if (ev[0]) m_end = 1; else if (cmd[5]) m_end = 0;
      if (ev[1]) m_tc = 1;  else if (cmd[6]) m_tc = 0;
      if (ev[3]) m_sus = 1; else if (cmd[9]) m_sus = 0;
      if (ev[2]) m_err = 1;
    end
    compare(req, a);
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    step(a, 1'b0, 0, 4'h0, req);
    chk(req, "explicit", bus_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_addr = 6'h24;
    compare("R1", 6'h24);
    rst_n = 1'b1;
    step(6'h24, 0, 0, 4'h0, "R1");

    // R11 start-up order
    step(6'h38, 1, 32'h1000_0040, 4'h0, "R11");
    step(6'h2C, 1, 32'h8040_0008, 4'h0, "R11");
    step(6'h28, 1, 32'h0000_0008, 4'h0, "R11");
    chk("R11", "idle after lone reset", run_en, 1'b0);
    step(6'h28, 1, 32'h0000_0005, 4'h0, "R11");
    chk("R11", "enable with trigger", {run_en, trig_pulse}, 2'b11);
    expect_rd(6'h24, 32'h1, "R11");

    // R2 / R3 readback
    expect_rd(6'h2C, 32'h8040_0008, "R2");
    expect_rd(6'h38, 32'h1000_0040, "R2");
    expect_rd(6'h28, 32'h0, "R3");
    expect_rd(6'h00, 32'h0, "R3");

    // R6 end flag
    step(6'h24, 0, 0, 4'h1, "R6");
    expect_rd(6'h24, 32'h21, "R6");
    step(6'h28, 1, 32'h20, 4'h0, "R6");
    chk("R6", "irq after clear", irq, 1'b0);
    expect_rd(6'h24, 32'h01, "R6");
    step(6'h28, 1, 32'h20, 4'h1, "R6");
    expect_rd(6'h24, 32'h21, "R6");
    step(6'h28, 1, 32'h20, 4'h0, "R6");

    // R7 tc and suspend
    step(6'h24, 0, 0, 4'hA, "R7");
    expect_rd(6'h24, 32'hC1, "R7");
    step(6'h28, 1, 32'h40, 4'h0, "R7");
    expect_rd(6'h24, 32'h81, "R7");
    step(6'h28, 1, 32'h200, 4'h8, "R7");
    expect_rd(6'h24, 32'h81, "R7");
    step(6'h28, 1, 32'h200, 4'h0, "R7");
    expect_rd(6'h24, 32'h01, "R7");

    // R4 enable set/clear
    step(6'h28, 1, 32'h2, 4'h0, "R4");
    chk("R4", "cleared", run_en, 1'b0);
    step(6'h28, 1, 32'h1, 4'h0, "R4");
    chk("R4", "set", run_en, 1'b1);
    step(6'h28, 1, 32'h3, 4'h0, "R4");
    chk("R4", "clear wins", run_en, 1'b0);

    // R5 pulses
    step(6'h28, 1, 32'h0002_0014, 4'h0, "R5");
    chk("R5", "pulse high", {trig_pulse, clr_req_pulse, clr_mask_pulse}, 3'b111);
    step(6'h24, 0, 0, 4'h0, "R5");
    chk("R5", "pulse gone", {trig_pulse, clr_req_pulse, clr_mask_pulse}, 3'b000);

    // R8 error beats set-enable
    step(6'h28, 1, 32'h1, 4'h4, "R8");
    chk("R8", "err state", {run_en, irq}, 2'b01);
    expect_rd(6'h24, 32'h10, "R8");
    step(6'h28, 1, 32'h20, 4'h0, "R8");
    expect_rd(6'h24, 32'h10, "R8");

    // R9 reset overrides events, keeps cfg/link
    step(6'h28, 1, 32'h1, 4'h0, "R9");
    step(6'h28, 1, 32'h8, 4'hB, "R9");
    chk("R9", "reset pulse", soft_rst_pulse, 1'b1);
    expect_rd(6'h24, 32'h0, "R9");
    expect_rd(6'h2C, 32'h8040_0008, "R9");
    expect_rd(6'h38, 32'h1000_0040, "R9");

    // R10 stop word
    step(6'h28, 1, 32'h1, 4'hB, "R10");
    step(6'h24, 0, 0, 4'h4, "R10");
    step(6'h28, 1, 32'h0002_027A, 4'h0, "R10");
    chk("R10", "irq low", irq, 1'b0);
    expect_rd(6'h24, 32'h0, "R10");

    // R2 reload
    step(6'h2C, 1, 32'hA5A5_0F0F, 4'h0, "R2");
    expect_rd(6'h2C, 32'hA5A5_0F0F, "R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule